// File: doc/BRIEF.md
# Message-signaled interrupt file

This block is one interrupt file for a single hart. Each interrupt identity has a pending bit and an enable bit. A device raises an interrupt by writing the identity number as a 32-bit word to offset zero of the block's message page. Software controls the file through a small register port. Through that port it can enable delivery, set a priority threshold, read or replace whole words of pending and enable bits, and read the top interrupt. A write to the top-interrupt register claims the winning interrupt.

Priority follows the identity number: the lowest-numbered identity that is both pending and enabled wins. A nonzero threshold hides every identity at or above its value. The single interrupt line to the hart is high whenever delivery is enabled and a winner exists. The number of identities is a parameter. It must be a multiple of 64, and identity 0 is reserved.

Top module: `msif_top`

## Requirements
- R1: After a synchronous reset, every pending bit, every enable bit, the threshold and the delivery enable are zero. Every register reads zero and `irq_o` is low.
- R2: A message write (`msg_we` high) with `msg_addr` equal to 0 and `msg_wdata` in the range 1 to NUM_IDS-1 sets the pending bit of that identity at the next rising clock edge.
- R3: A message write is ignored in any of these cases: its data is 0, its data is NUM_IDS or larger, its address is misaligned, it targets a nonzero offset, or it falls outside the 4096-byte page.
- R4: The pending bit and the enable bit of identity 0 always read as zero, and writes do not change them.
- R5: An identity is a candidate only when both its pending bit and its enable bit are set. The winner is the lowest-numbered candidate, counting from identity 1.
- R6: If the threshold is nonzero and no larger than NUM_IDS, only identities strictly below the threshold are candidates. A threshold of zero, or one larger than NUM_IDS, applies no filter.
- R7: Reading the top-interrupt register (`reg_sel` 8'h02) returns the winner in bits 26:16 and again in bits 10:0, with all other bits zero. It returns 0 when there is no candidate.
- R8: Any write to the top-interrupt register ignores its data. It clears the pending bit of the current winner, if one exists. With no winner, it changes nothing.
- R9: The delivery register (`reg_sel` 8'h00) keeps only bit 0 of a write. The threshold register (`reg_sel` 8'h01) keeps only bits 10:0. Both read back in the same bit positions.
- R10: `irq_o` is high exactly when delivery is enabled and a winner exists. It follows any state change at the edge where that state is written.
- R11: `reg_sel` 8'h40+k selects pending word k and 8'h80+k selects enable word k, for k below NUM_IDS/32. Bit j of word k covers identity 32k+j. A write replaces the whole word, and the register reads return the current contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msg_we | input | 1 | Message page write strobe |
| msg_addr | input | MSG_AW | Byte address within the message region |
| msg_wdata | input | 32 | Message data, the identity number |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 8 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_sel` |
| irq_o | output | 1 | External interrupt line to the hart |

## Verification
Every register read is a combinational view of registered state. A message or register write therefore shows up in `reg_rdata` and `irq_o` exactly one cycle after it is presented: the state changes at the rising edge, and both outputs follow directly from that state. The bench applies each write at a falling edge and removes it at the next falling edge. It then reads and samples at that same falling edge, so every check sees the state left by exactly the rising edge in between. Reads are set up with no write pending and sampled one nanosecond later, away from any edge.

// File: rtl/msif_pkg.sv
package msif_pkg;
    localparam int FLD_W     = 11;
    localparam int ID_SHIFT  = 16;
    localparam int PAGE_B    = 4096;

    localparam logic [7:0] SEL_DELIV  = 8'h00;
    localparam logic [7:0] SEL_THRESH = 8'h01;
    localparam logic [7:0] SEL_TOP    = 8'h02;
    localparam logic [1:0] GRP_PEND   = 2'b01;
    localparam logic [1:0] GRP_ENAB   = 2'b10;

    typedef struct packed {
        logic             deliv;
        logic [FLD_W-1:0] thresh;
    } ctrl_t;
endpackage

// File: rtl/msif_bank.sv
module msif_bank #(
    parameter int NUM_IDS = 64,
    localparam int ID_W    = $clog2(NUM_IDS),
    localparam int NWORDS  = NUM_IDS / 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               word_we,
    input  logic               word_is_pend,
    input  logic [5:0]         word_idx,
    input  logic [31:0]        word_data,
    input  logic               clr_en,
    input  logic [ID_W-1:0]    clr_id,
    input  logic               set_en,
    input  logic [ID_W-1:0]    set_id,
    output logic [NUM_IDS-1:0] pend,
    output logic [NUM_IDS-1:0] enab
);
    typedef struct packed {
        logic [NUM_IDS-1:0] pend;
        logic [NUM_IDS-1:0] enab;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (word_we) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (int'(word_idx) == w) begin
                    if (word_is_pend) s_d.pend[w*32 +: 32] = word_data;
                    else              s_d.enab[w*32 +: 32] = word_data;
                end
            end
        end
        if (clr_en) s_d.pend[clr_id] = 1'b0;
        if (set_en) s_d.pend[set_id] = 1'b1;
        s_d.pend[0] = 1'b0;
        s_d.enab[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign pend = s_q.pend;
    assign enab = s_q.enab;
endmodule

// File: rtl/msif_select.sv
module msif_select #(
    parameter int NUM_IDS = 64,
    localparam int ID_W   = $clog2(NUM_IDS)
) (
    input  logic [NUM_IDS-1:0]        pend,
    input  logic [NUM_IDS-1:0]        enab,
    input  logic [msif_pkg::FLD_W-1:0] thresh,
    output logic [ID_W-1:0]           top_id,
    output logic                      found
);
    logic [NUM_IDS-1:0] cand;
    int                 limit;

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_cand
        assign cand[g] = pend[g] & enab[g];
    end

    always_comb begin
        limit  = (thresh != '0 && int'(thresh) <= NUM_IDS) ? int'(thresh) : NUM_IDS;
        top_id = '0;
        found  = 1'b0;
        for (int i = NUM_IDS - 1; i >= 1; i--) begin
            if (cand[i] && i < limit) begin
                top_id = ID_W'(i);
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/msif_top.sv
module msif_top #(
    parameter int NUM_IDS = 64,
    parameter int MSG_AW  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_we,
    input  logic [MSG_AW-1:0] msg_addr,
    input  logic [31:0]       msg_wdata,
    input  logic              reg_we,
    input  logic [7:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_o
);
    import msif_pkg::*;

    localparam int ID_W   = $clog2(NUM_IDS);
    localparam int NWORDS = NUM_IDS / 32;

    ctrl_t              ctrl_d, ctrl_q;
    logic [NUM_IDS-1:0] pend, enab;
    logic [ID_W-1:0]    top_id;
    logic               found;
    logic               msg_ok;
    logic [ID_W-1:0]    msg_id;
    logic               claim;
    logic               word_sel, word_is_pend, word_we;
    logic [5:0]         word_idx;
    logic [31:0]        word_rd;

    assign msg_ok = msg_we && (msg_addr == '0) && (msg_wdata != '0)
                    && (msg_wdata < 32'(NUM_IDS));
    assign msg_id = msg_wdata[ID_W-1:0];

    assign word_idx     = reg_sel[5:0];
    assign word_is_pend = (reg_sel[7:6] == GRP_PEND);
    assign word_sel     = (word_is_pend || reg_sel[7:6] == GRP_ENAB)
                          && (int'(word_idx) < NWORDS);
    assign word_we      = reg_we && word_sel;
    assign claim        = reg_we && (reg_sel == SEL_TOP) && found;

    msif_bank #(.NUM_IDS(NUM_IDS)) u_bank (
        .clk(clk), .rst(rst),
        .word_we(word_we), .word_is_pend(word_is_pend),
        .word_idx(word_idx), .word_data(reg_wdata),
        .clr_en(claim), .clr_id(top_id),
        .set_en(msg_ok), .set_id(msg_id),
        .pend(pend), .enab(enab)
    );

    msif_select #(.NUM_IDS(NUM_IDS)) u_sel (
        .pend(pend), .enab(enab), .thresh(ctrl_q.thresh),
        .top_id(top_id), .found(found)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_we && reg_sel == SEL_DELIV)  ctrl_d.deliv  = reg_wdata[0];
        if (reg_we && reg_sel == SEL_THRESH) ctrl_d.thresh = reg_wdata[FLD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    always_comb begin
        word_rd = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (int'(word_idx) == w)
                word_rd = word_is_pend ? pend[w*32 +: 32] : enab[w*32 +: 32];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_DELIV)
            reg_rdata = {31'b0, ctrl_q.deliv};
        else if (reg_sel == SEL_THRESH)
            reg_rdata = {{(32-FLD_W){1'b0}}, ctrl_q.thresh};
        else if (reg_sel == SEL_TOP && found)
            reg_rdata = {5'b0, FLD_W'(top_id), 5'b0, FLD_W'(top_id)};
        else if (word_sel)
            reg_rdata = word_rd;
    end

    assign irq_o = ctrl_q.deliv && found;
endmodule

// File: rtl/msif_checker.sv
module msif_checker #(
    parameter int NUM_IDS = 64,
    localparam int ID_W   = $clog2(NUM_IDS)
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_o,
    input logic               deliv,
    input logic [10:0]        thresh,
    input logic               found,
    input logic [ID_W-1:0]    top_id,
    input logic [NUM_IDS-1:0] pend,
    input logic [NUM_IDS-1:0] enab,
    input logic               msg_ok,
    input logic [ID_W-1:0]    msg_id,
    input logic               claim,
    input logic               word_we
);
    // R2
    msg_sets_chk: assert property (@(posedge clk) disable iff (rst)
        msg_ok |=> pend[$past(msg_id)]);

    // R4
    id_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !pend[0] && !enab[0]);

    // R5
    winner_valid_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> (top_id != '0 && pend[top_id] && enab[top_id]));

    // R6
    thresh_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (found && thresh != '0 && int'(thresh) <= NUM_IDS) |-> (int'(top_id) < int'(thresh)));

    // R8
    claim_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (claim && !word_we && !(msg_ok && msg_id == top_id)) |=> !pend[$past(top_id)]);

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (deliv && pend != '0 && enab != '0));
endmodule

bind msif_top msif_checker #(.NUM_IDS(NUM_IDS)) u_chk (
    .clk(clk), .rst(rst), .irq_o(irq_o), .deliv(ctrl_q.deliv),
    .thresh(ctrl_q.thresh), .found(found), .top_id(top_id),
    .pend(pend), .enab(enab), .msg_ok(msg_ok), .msg_id(msg_id),
    .claim(claim), .word_we(word_we)
);

// File: tb/msif_top_test.sv
`timescale 1ns/1ps
module msif_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msg_we = 1'b0;
    logic [15:0] msg_addr = '0;
    logic [31:0] msg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    msif_top #(.NUM_IDS(64), .MSG_AW(16)) uut (
        .clk(clk), .rst(rst), .msg_we(msg_we), .msg_addr(msg_addr),
        .msg_wdata(msg_wdata), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [7:0] sel, logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [7:0] sel, output logic [31:0] data);
        reg_sel = sel;
        #1;
        data = reg_rdata;
    endtask

    task automatic rd_check(string req, logic [7:0] sel, logic [31:0] exp);
        logic [31:0] v;
        reg_rd(sel, v);
        check(req, v, exp);
    endtask

    task automatic send_msg(logic [15:0] addr, logic [31:0] data);
        @(negedge clk);
        msg_we = 1'b1; msg_addr = addr; msg_wdata = data;
        @(negedge clk);
        msg_we = 1'b0;
    endtask

    task automatic t_reset;
        rd_check("R1 deliv", 8'h00, 0);
        rd_check("R1 thresh", 8'h01, 0);
        rd_check("R1 top", 8'h02, 0);
        rd_check("R1 pend0", 8'h40, 0);
        rd_check("R1 pend1", 8'h41, 0);
        rd_check("R1 enab0", 8'h80, 0);
        rd_check("R1 enab1", 8'h81, 0);
        check("R1 irq", {31'b0, irq_o}, 0);
    endtask

    task automatic t_msg;
        send_msg(16'h0000, 32'd3);
        rd_check("R2 id3", 8'h40, 32'h0000_0008);
        send_msg(16'h0000, 32'd45);
        rd_check("R2 id45", 8'h41, 32'h0000_2000);
        check("R10 irq off while disabled", {31'b0, irq_o}, 0);
    endtask

    task automatic t_bad;
        send_msg(16'h0000, 32'd0);
        send_msg(16'h0000, 32'd64);
        send_msg(16'h0000, 32'h0001_0003);
        send_msg(16'h0004, 32'd7);
        send_msg(16'h0001, 32'd7);
        send_msg(16'h1000, 32'd7);
        rd_check("R3 pend0 unchanged", 8'h40, 32'h0000_0008);
        rd_check("R3 pend1 unchanged", 8'h41, 32'h0000_2000);
    endtask

    task automatic t_words;
        reg_wr(8'h40, 32'hFFFF_FFFF);
        reg_wr(8'h80, 32'hFFFF_FFFF);
        rd_check("R4 pend bit0", 8'h40, 32'hFFFF_FFFE);
        rd_check("R4 enab bit0", 8'h80, 32'hFFFF_FFFE);
        send_msg(16'h0000, 32'd0);
        rd_check("R4 pend bit0 after msg", 8'h40, 32'hFFFF_FFFE);
        reg_wr(8'h40, 32'h0);
        reg_wr(8'h41, 32'h0);
        reg_wr(8'h80, 32'h0);
        rd_check("R11 pend0 cleared", 8'h40, 0);
        rd_check("R11 pend1 cleared", 8'h41, 0);
        rd_check("R11 enab0 cleared", 8'h80, 0);
        rd_check("R7 no candidate", 8'h02, 0);
    endtask

    task automatic t_prio;
        reg_wr(8'h80, 32'h0000_0220);
        reg_wr(8'h81, 32'h0000_0100);
        rd_check("R11 enab0", 8'h80, 32'h0000_0220);
        rd_check("R5 enabled only", 8'h02, 0);
        send_msg(16'h0000, 32'd9);
        rd_check("R7 top 9", 8'h02, 32'h0009_0009);
        send_msg(16'h0000, 32'd40);
        rd_check("R5 lower wins", 8'h02, 32'h0009_0009);
        send_msg(16'h0000, 32'd5);
        rd_check("R5 new lowest", 8'h02, 32'h0005_0005);
        send_msg(16'h0000, 32'd7);
        rd_check("R5 not enabled", 8'h02, 32'h0005_0005);
    endtask

    task automatic t_irq;
        check("R10 irq deliv off", {31'b0, irq_o}, 0);
        reg_wr(8'h00, 32'h1);
        check("R10 irq on", {31'b0, irq_o}, 1);
        reg_wr(8'h00, 32'hFFFF_FFFE);
        rd_check("R9 deliv bit0 only", 8'h00, 0);
        check("R10 irq off again", {31'b0, irq_o}, 0);
        reg_wr(8'h00, 32'h1);
        rd_check("R9 deliv reads 1", 8'h00, 1);
    endtask

    task automatic t_thresh;
        reg_wr(8'h01, 32'd5);
        rd_check("R6 thr5 top", 8'h02, 0);
        check("R10 irq masked", {31'b0, irq_o}, 0);
        reg_wr(8'h01, 32'd6);
        rd_check("R6 thr6 top", 8'h02, 32'h0005_0005);
        check("R10 irq back", {31'b0, irq_o}, 1);
        reg_wr(8'h01, 32'hFFFF_F805);
        rd_check("R9 thresh mask", 8'h01, 32'd5);
        rd_check("R6 masked value", 8'h02, 0);
        reg_wr(8'h01, 32'd100);
        rd_check("R6 above count", 8'h02, 32'h0005_0005);
        reg_wr(8'h01, 32'd64);
        rd_check("R6 equal count", 8'h02, 32'h0005_0005);
        reg_wr(8'h01, 32'd10);
        reg_wr(8'h40, 32'h0000_0280);
        rd_check("R6 thr10 top9", 8'h02, 32'h0009_0009);
        reg_wr(8'h01, 32'd9);
        rd_check("R6 thr9 none", 8'h02, 0);
        reg_wr(8'h01, 32'd0);
        reg_wr(8'h40, 32'h0000_02A0);
        rd_check("R6 zero no filter", 8'h02, 32'h0005_0005);
    endtask

    task automatic t_claim;
        reg_wr(8'h02, 32'hDEAD_BEEF);
        rd_check("R8 claim 5", 8'h40, 32'h0000_0280);
        rd_check("R8 next top", 8'h02, 32'h0009_0009);
        reg_wr(8'h02, 32'h0);
        rd_check("R8 top 40", 8'h02, 32'h0028_0028);
        reg_wr(8'h02, 32'h1234);
        rd_check("R8 empty", 8'h02, 0);
        check("R10 irq none", {31'b0, irq_o}, 0);
        reg_wr(8'h02, 32'hFFFF_FFFF);
        rd_check("R8 no winner pend0", 8'h40, 32'h0000_0080);
        rd_check("R8 no winner pend1", 8'h41, 0);
        send_msg(16'h0000, 32'd5);
        rd_check("R2 again", 8'h02, 32'h0005_0005);
        check("R10 irq re-raised", {31'b0, irq_o}, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_msg();
        t_bad();
        t_words();
        t_prio();
        t_irq();
        t_thresh();
        t_claim();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule